// File: doc/BRIEF.md
# Byte-Wide Configuration Loader for a Programmable Device

This block loads a configuration image into a downstream programmable device through that device's byte-wide configuration port. A single start pulse begins a run. The block first holds the device's program request, then waits until the device reports that it is ready. It then opens the port, writing first and selecting second. Image bytes come from a valid/ready stream, and the block puts one byte on the data bus for each rising edge of the configuration clock. It closes the port in the reverse order and keeps toggling the configuration clock until the device reports completion.

All device-side pins are active high at this boundary; any pad inversion sits outside the block. The configuration clock is made from the system clock by a half-period divider. The divider is sized so that the configuration clock never runs faster than a parameterized limit. A run-time enable selects a busy handshake. With it set, the block keeps clocking the same byte while the device reports busy. Each waiting phase has its own timeout, and the timeout that expires is reported as a distinct error code together with an abort indication.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset, dev_prog_o, dev_cs_o, dev_wr_o, dev_abort_o, run_o, ok_o and s_ready_o are 0, dev_cclk_o is 1 and err_o is 0.
- R2: A start pulse while idle raises run_o and holds dev_prog_o high for PROG_TICKS divider ticks. The block then waits until dev_init_i is 1 and dev_busy_i is 0 before it opens the port. A start pulse while run_o is 1 is ignored.
- R3: When the port opens, dev_wr_o rises strictly before dev_cs_o, and dev_cclk_o is 1 when dev_cs_o rises.
- R4: Each accepted stream byte is driven on dev_dq_o and stays stable across exactly one rising edge of dev_cclk_o with dev_cs_o and dev_wr_o high. Bytes go out in stream order, and s_ready_o is 1 only while the port is open.
- R5: With busy_chk_en_i = 1, each cycle in which dev_busy_i is 1 after a byte's clock edge yields one extra rising edge that carries the same byte, and no further stream byte is accepted until dev_busy_i is 0.
- R6: With busy_chk_en_i = 0, dev_busy_i has no effect during loading: each byte gets exactly one rising edge.
- R7: After the byte marked by s_last_i, dev_cs_o falls strictly before dev_wr_o on a run that does not abort.
- R8: After the port closes, dev_cclk_o keeps toggling until dev_done_i is 1; the run then ends with ok_o = 1, err_o = 0 and run_o = 0.
- R9: A timeout ends the run with run_o = 0, ok_o = 0, dev_abort_o = 1 and the port closed. err_o is 1 for the ready wait, 2 for the busy wait and 3 for the completion wait.
- R10: On the clock edge that accepts a start, err_o, ok_o and dev_abort_o return to 0.
- R11: Every level of dev_cclk_o lasts at least HALF_DIV system clock cycles, where HALF_DIV = ceil(CLK_HZ / (2 * CCLK_MAX_HZ)).

Each run's timeout window is TIMEOUT_CYC system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a run |
| busy_chk_en_i | input | 1 | Enables the busy handshake during loading |
| s_valid_i | input | 1 | Image stream byte valid |
| s_data_i | input | 8 | Image stream byte |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Image stream byte accepted this cycle |
| dev_prog_o | output | 1 | Program request to the device |
| dev_cs_o | output | 1 | Device select |
| dev_wr_o | output | 1 | Write direction enable |
| dev_cclk_o | output | 1 | Configuration clock |
| dev_dq_o | output | 8 | Configuration data bus |
| dev_init_i | input | 1 | Device initialisation finished |
| dev_busy_i | input | 1 | Device cannot take a byte |
| dev_done_i | input | 1 | Device configuration complete |
| dev_abort_o | output | 1 | Run aborted on a timeout, held until the next start |
| run_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run completed |
| err_o | output | 2 | Timeout cause of the last run |

## Verification
A plain image with stream bubbles and no busy response gives the one-edge-per-byte baseline and the open and close ordering of the select and write pins. A second image has the device assert busy for two and then one extra edges on chosen bytes, which separates a byte that is repeated from one that advances. A third image keeps busy high throughout with the handshake disabled, which shows that the input is then ignored. Three runs let one waiting phase stall in turn (ready, busy, completion) to tell the error codes apart, and a final clean run shows that status clears on start.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int CFGL_BUS_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WRDY,
        ST_SETW,
        ST_SETC,
        ST_LOAD,
        ST_CLO,
        ST_CHI,
        ST_AFT,
        ST_RELW,
        ST_DCHK,
        ST_DHI
    } cfgl_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_READY = 2'd1,
        ERR_BUSY  = 2'd2,
        ERR_DONE  = 2'd3
    } cfgl_err_e;

endpackage

// File: rtl/cfgl_tick.sv
module cfgl_tick #(
    parameter int DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == CW'(DIV - 1)) cnt_d = '0;
                else                       cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == CW'(DIV - 1));

            AST_TICK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o) else $error("tick repeated"); // R11
        end
    endgenerate
endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic exp_o
);
    localparam int TW = $clog2(LIMIT + 1);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (!exp_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign exp_o = (cnt_q >= TW'(LIMIT));

    AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exp_o && !clr_i) |=> exp_o) else $error("timer dropped"); // R9
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
    import cfgl_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int CCLK_MAX_HZ = 50_000_000,
    parameter int PROG_TICKS  = 4,
    parameter int TIMEOUT_CYC = CLK_HZ / 100
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic                  busy_chk_en_i,
    input  logic                  s_valid_i,
    input  logic [CFGL_BUS_W-1:0] s_data_i,
    input  logic                  s_last_i,
    output logic                  s_ready_o,
    output logic                  dev_prog_o,
    output logic                  dev_cs_o,
    output logic                  dev_wr_o,
    output logic                  dev_cclk_o,
    output logic [CFGL_BUS_W-1:0] dev_dq_o,
    input  logic                  dev_init_i,
    input  logic                  dev_busy_i,
    input  logic                  dev_done_i,
    output logic                  dev_abort_o,
    output logic                  run_o,
    output logic                  ok_o,
    output logic [1:0]            err_o
);
    localparam int HALF_DIV = (CLK_HZ + 2 * CCLK_MAX_HZ - 1) / (2 * CCLK_MAX_HZ);
    localparam int PW       = $clog2(PROG_TICKS + 1);
    localparam int GW       = $clog2(HALF_DIV + 1) + 1;

    typedef struct packed {
        cfgl_state_e           st;
        logic                  prog;
        logic                  cs;
        logic                  wr;
        logic                  cclk;
        logic                  last;
        logic                  run;
        logic                  ok;
        logic                  abort;
        cfgl_err_e             err;
        logic [CFGL_BUS_W-1:0] dq;
        logic [PW-1:0]         pcnt;
    } ctl_t;

    ctl_t st_d, st_q;
    logic tick, tmo, tmr_clr, rdy;

    cfgl_tick #(.DIV(HALF_DIV)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    cfgl_timer #(.LIMIT(TIMEOUT_CYC)) tmr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tmr_clr),
        .exp_o  (tmo)
    );

    function automatic ctl_t end_fail(ctl_t c, cfgl_err_e code);
        ctl_t r;
        r       = c;
        r.st    = ST_IDLE;
        r.err   = code;
        r.abort = 1'b1;
        r.run   = 1'b0;
        r.prog  = 1'b0;
        r.cs    = 1'b0;
        r.wr    = 1'b0;
        r.cclk  = 1'b1;
        return r;
    endfunction

    always_comb begin
        st_d    = st_q;
        tmr_clr = 1'b0;
        rdy     = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.st    = ST_PROG;
                    st_d.prog  = 1'b1;
                    st_d.pcnt  = '0;
                    st_d.run   = 1'b1;
                    st_d.ok    = 1'b0;
                    st_d.abort = 1'b0;
                    st_d.err   = ERR_NONE;
                    st_d.cclk  = 1'b1;
                    tmr_clr    = 1'b1;
                end
            end
            ST_PROG: begin
                if (tick) begin
                    if (st_q.pcnt == PW'(PROG_TICKS - 1)) begin
                        st_d.prog = 1'b0;
                        st_d.st   = ST_WRDY;
                        tmr_clr   = 1'b1;
                    end else begin
                        st_d.pcnt = st_q.pcnt + 1'b1;
                    end
                end
            end
            ST_WRDY: begin
                if (tick) begin
                    if (dev_init_i && !dev_busy_i) st_d.st = ST_SETW;
                    else if (tmo)                  st_d = end_fail(st_q, ERR_READY);
                end
            end
            ST_SETW: begin
                if (tick) begin
                    st_d.wr = 1'b1;
                    st_d.st = ST_SETC;
                end
            end
            ST_SETC: begin
                if (tick) begin
                    st_d.cs   = 1'b1;
                    st_d.cclk = 1'b1;
                    st_d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (tick) begin
                    rdy = 1'b1;
                    if (s_valid_i) begin
                        st_d.dq   = s_data_i;
                        st_d.last = s_last_i;
                        st_d.st   = ST_CLO;
                        tmr_clr   = 1'b1;
                    end
                end
            end
            ST_CLO: begin
                if (tick) begin
                    st_d.cclk = 1'b0;
                    st_d.st   = ST_CHI;
                end
            end
            ST_CHI: begin
                if (tick) begin
                    st_d.cclk = 1'b1;
                    st_d.st   = ST_AFT;
                end
            end
            ST_AFT: begin
                if (tick) begin
                    if (busy_chk_en_i && dev_busy_i) begin
                        if (tmo) begin
                            st_d = end_fail(st_q, ERR_BUSY);
                        end else begin
                            st_d.cclk = 1'b0;
                            st_d.st   = ST_CHI;
                        end
                    end else if (st_q.last) begin
                        st_d.cs = 1'b0;
                        st_d.st = ST_RELW;
                    end else begin
                        st_d.st = ST_LOAD;
                    end
                end
            end
            ST_RELW: begin
                if (tick) begin
                    st_d.wr = 1'b0;
                    st_d.st = ST_DCHK;
                    tmr_clr = 1'b1;
                end
            end
            ST_DCHK: begin
                if (tick) begin
                    if (dev_done_i) begin
                        st_d.ok  = 1'b1;
                        st_d.run = 1'b0;
                        st_d.st  = ST_IDLE;
                    end else if (tmo) begin
                        st_d = end_fail(st_q, ERR_DONE);
                    end else begin
                        st_d.cclk = 1'b0;
                        st_d.st   = ST_DHI;
                    end
                end
            end
            ST_DHI: begin
                if (tick) begin
                    st_d.cclk = 1'b1;
                    st_d.st   = ST_DCHK;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.st    <= ST_IDLE;
            st_q.err   <= ERR_NONE;
            st_q.cclk  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready_o   = rdy;
    assign dev_prog_o  = st_q.prog;
    assign dev_cs_o    = st_q.cs;
    assign dev_wr_o    = st_q.wr;
    assign dev_cclk_o  = st_q.cclk;
    assign dev_dq_o    = st_q.dq;
    assign dev_abort_o = st_q.abort;
    assign run_o       = st_q.run;
    assign ok_o        = st_q.ok;
    assign err_o       = st_q.err;

    // cycles since the last clock level change, saturating at HALF_DIV
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     gap_q <= GW'(HALF_DIV);
        else if (st_d.cclk != st_q.cclk) gap_q <= GW'(1);
        else if (gap_q < GW'(HALF_DIV))  gap_q <= gap_q + 1'b1;
    end

    AST_CCLK_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_d.cclk != st_q.cclk) |-> (gap_q >= GW'(HALF_DIV))) else $error("cclk too fast"); // R11
    AST_CS_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dev_cs_o |-> dev_wr_o) else $error("select without write"); // R3
    AST_READY_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_ready_o |-> (dev_cs_o && dev_wr_o && dev_cclk_o)) else $error("ready outside load"); // R4
    AST_DQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(dev_cclk_o) && dev_cs_o) |-> $stable(dev_dq_o)) else $error("data moved at edge"); // R4
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && !dev_prog_o && start_i) |=> !dev_prog_o) else $error("restart while running"); // R2
    AST_CS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(dev_cs_o) && !dev_abort_o) |-> dev_wr_o) else $error("write dropped with select"); // R7
    AST_OK_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ok_o |-> (err_o == 2'd0 && !dev_abort_o && !run_o)) else $error("ok with error"); // R8
    AST_ABORT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dev_abort_o |-> (err_o != 2'd0 && !dev_cs_o && !dev_wr_o)) else $error("abort without code"); // R9

endmodule

// File: tb/cfg_par_loader_tb_top.sv
module cfg_par_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 200_000_000;
    localparam int CMAX_HZ    = 50_000_000;
    localparam int PROG_T     = 3;
    localparam int TMO        = 400;
    localparam int HALF       = (CLK_HZ + 2 * CMAX_HZ - 1) / (2 * CMAX_HZ);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, busy_en = 1'b1;
    logic s_valid = 1'b0, s_last = 1'b0;
    logic [7:0] s_data = '0;
    logic s_ready, prog, cs, wr, cclk, abort_o, run, ok;
    logic [7:0] dq;
    logic [1:0] err;
    logic init_r = 1'b0, done_r = 1'b0, busy_model = 1'b0, busy_force = 1'b0;
    wire  busy_w = busy_model | busy_force;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_par_loader #(
        .CLK_HZ(CLK_HZ), .CCLK_MAX_HZ(CMAX_HZ), .PROG_TICKS(PROG_T), .TIMEOUT_CYC(TMO)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .busy_chk_en_i(busy_en),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
        .dev_prog_o(prog), .dev_cs_o(cs), .dev_wr_o(wr), .dev_cclk_o(cclk), .dev_dq_o(dq),
        .dev_init_i(init_r), .dev_busy_i(busy_w), .dev_done_i(done_r),
        .dev_abort_o(abort_o), .run_o(run), .ok_o(ok), .err_o(err)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!c) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // scoreboard queue filled by the driver, drained by the monitor
    logic [7:0] exp_q[$];

    // device model configuration (per run)
    int  init_dly = 4;  bit init_nev = 0;
    int  done_tgt = 0;  bit done_nev = 0;
    bit  force_dis = 0; bit stuck = 0;
    int  plan [0:15];

    // monitor state (per run)
    int cyc = 0, since_prog = 0, prog_rises = 0, prog_len = 0;
    int t_init = -1, t_wr_r = -1, t_cs_r = -1, t_cs_f = -1, t_wr_f = -1;
    int data_edges = 0, rep_edges = 0, rep_bad = 0, done_edges = 0, rdy_bad = 0;
    int busy_cnt = 0, last_tog = -1000, min_gap = 1000;
    bit cclk_at_cs = 0, prog_seen = 0;
    logic [7:0] last_dq = '0;
    logic p_prog = 0, p_cs = 0, p_wr = 0, p_cclk = 1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prog && !p_prog) begin prog_rises++; prog_seen = 1; end
            if (prog) begin
                prog_len++; init_r = 0; done_r = 0; busy_model = 0; since_prog = 0;
            end else if (prog_seen && !init_r && !init_nev) begin
                since_prog++;
                if (since_prog >= init_dly) begin init_r = 1; t_init = cyc; end
            end
            if (wr && !p_wr) begin t_wr_r = cyc; if (force_dis) busy_force = 1; end
            if (cs && !p_cs) begin t_cs_r = cyc; cclk_at_cs = cclk; end
            if (!cs && p_cs) t_cs_f = cyc;
            if (!wr && p_wr) begin
                t_wr_f = cyc; busy_force = 0;
                if (done_tgt == 0 && !done_nev) done_r = 1;
            end
            if (cclk != p_cclk) begin
                if (cyc - last_tog < min_gap) min_gap = cyc - last_tog;
                last_tog = cyc;
            end
            if (cclk && !p_cclk) begin
                if (cs && wr) begin
                    if (busy_cnt > 0 || (busy_force && busy_en)) begin
                        rep_edges++;
                        if (dq != last_dq) rep_bad++;
                        if (busy_cnt > 0) begin
                            busy_cnt--;
                            if (busy_cnt == 0) busy_model = 0;
                        end
                    end else begin
                        if (exp_q.size() == 0) chk(0, "R4", "byte with empty queue", dq, -1);
                        else chk(dq == exp_q.pop_front(), "R4", "byte order/value", dq, -2);
                        last_dq = dq;
                        if (busy_en && data_edges < 16 && plan[data_edges] > 0) begin
                            busy_cnt = plan[data_edges]; busy_model = 1;
                        end
                        if (stuck) busy_force = 1;
                        data_edges++;
                    end
                end else if (!cs && !wr && run && !prog) begin
                    done_edges++;
                    if (!done_nev && done_edges == done_tgt) done_r = 1;
                end
            end
            if (s_ready && !(cs && wr)) rdy_bad++;
        end
        p_prog = prog; p_cs = cs; p_wr = wr; p_cclk = cclk;
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            chk(0, "R1", "watchdog expired", cyc, 150000);
            summary();
        end
    end

    task automatic wait_idle();
        int k = 0;
        while (run && k < 20000) begin @(negedge clk); k++; end
        chk(!run, "R9", "run ended", run, 0);
    endtask

    task automatic do_run(input int n, input bit ben, input int seed, input int exp_err, input string tag);
        int n_rep = 0;
        foreach (plan[i]) n_rep += plan[i];
        prog_rises = 0; prog_len = 0; prog_seen = 0; since_prog = 0;
        t_init = -1; t_wr_r = -1; t_cs_r = -1; t_cs_f = -1; t_wr_f = -1;
        data_edges = 0; rep_edges = 0; rep_bad = 0; done_edges = 0; rdy_bad = 0;
        busy_cnt = 0; last_tog = -1000; min_gap = 1000; busy_force = 0;
        busy_en = ben;
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
        chk(err == 0 && !ok && !abort_o && run, "R10", {tag, " status cleared on start"},
            {err, ok, abort_o, run}, 1);
        repeat (2) @(negedge clk);
        start_i = 1;
        @(negedge clk) start_i = 0;
        for (int i = 0; i < n; i++) begin
            bit taken = 0;
            s_valid = 1; s_data = 8'((seed * 37 + i * 29 + 5) & 255); s_last = (i == n - 1);
            while (!taken && run) begin
                if (s_ready) begin exp_q.push_back(s_data); taken = 1; end
                @(negedge clk);
            end
            s_valid = 0;
            if (!run) break;
            if (i % 2 == 1) @(negedge clk);
        end
        s_valid = 0; s_last = 0;
        wait_idle();
        chk(prog_rises == 1, "R2", {tag, " one program pulse despite second start"}, prog_rises, 1);
        chk(min_gap >= HALF, "R11", {tag, " min cclk level length"}, min_gap, HALF);
        chk(rdy_bad == 0, "R4", {tag, " ready only while port open"}, rdy_bad, 0);
        if (exp_err == 0) begin
            chk(prog_len >= (PROG_T - 1) * HALF + 1 && prog_len <= PROG_T * HALF, "R2",
                {tag, " program pulse length"}, prog_len, PROG_T * HALF);
            chk(t_init > 0 && t_wr_r > t_init, "R2", {tag, " port opens after ready"}, t_wr_r, t_init + 1);
            chk(t_cs_r > t_wr_r, "R3", {tag, " write before select"}, t_cs_r, t_wr_r + 1);
            chk(cclk_at_cs, "R3", {tag, " clock high at select"}, cclk_at_cs, 1);
            chk(data_edges == n && exp_q.size() == 0, "R4", {tag, " one edge per byte"}, data_edges, n);
            chk(rep_edges == (ben ? n_rep : 0) && rep_bad == 0, ben ? "R5" : "R6",
                {tag, " repeated edges"}, rep_edges, ben ? n_rep : 0);
            chk(t_wr_f > t_cs_f && t_cs_f > t_cs_r, "R7", {tag, " select drops before write"}, t_wr_f, t_cs_f + 1);
            chk(ok && err == 0 && !abort_o, "R8", {tag, " completion status"}, {ok, err, abort_o}, 4'b1000);
            chk(done_edges == done_tgt, "R8", {tag, " clocks until done"}, done_edges, done_tgt);
        end else begin
            chk(err == 2'(exp_err) && abort_o && !ok && !cs && !wr, "R9", {tag, " timeout cause"},
                err, exp_err);
        end
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        foreach (plan[i]) plan[i] = 0;
        repeat (3) @(negedge clk);
        chk(!prog && !cs && !wr && cclk && !run && !ok && err == 0 && !abort_o && !s_ready,
            "R1", "reset state", {prog, cs, wr, cclk, run}, 5'b00010);
        rst_n = 1;
        @(negedge clk);
        chk(!prog && !cs && !wr && cclk && !run && err == 0 && !s_ready, "R1", "idle after reset",
            {prog, cs, wr, cclk, run}, 5'b00010);

        // baseline: bubbles, no busy, three done clocks
        init_dly = 5; done_tgt = 3;
        do_run(6, 1'b1, 1, 0, "plain");

        // busy handshake: byte1 two extra edges, byte3 one extra
        plan[1] = 2; plan[3] = 1; done_tgt = 0;
        do_run(5, 1'b1, 2, 0, "busy");
        plan[1] = 0; plan[3] = 0;

        // busy held high but handshake off: R6
        force_dis = 1; done_tgt = 2;
        do_run(4, 1'b0, 3, 0, "busy_off");
        force_dis = 0;

        // ready never arrives
        init_nev = 1;
        do_run(3, 1'b1, 4, 1, "t_ready");
        init_nev = 0;

        // busy stuck after first byte
        stuck = 1;
        do_run(4, 1'b1, 5, 2, "t_busy");
        stuck = 0; busy_force = 0;
        chk(done_edges == 0, "R5", "stuck busy held the stream", done_edges, 0);

        // done never arrives
        done_nev = 1;
        do_run(2, 1'b1, 6, 3, "t_done");
        chk(done_edges > 0, "R8", "clocking during completion wait", done_edges, 1);
        done_nev = 0;

        // recovery after failure
        done_tgt = 1;
        do_run(3, 1'b1, 7, 0, "recover");
        summary();
    end
endmodule